// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Control

This block is the hazard control for a five-stage integer pipeline (fetch, decode, execute, memory, write-back). For the instruction now in the execute stage it compares each source register number against the destination numbers carried by the two later pipeline registers. It then steers each ALU operand multiplexer to one of three inputs: the value read from the register file during decode, the result waiting in the execute/memory register, or the data waiting in the memory/write-back register. The last of these can be a value just loaded from memory.

It also watches for a load in the execute stage whose destination is read by the instruction in decode. That case cannot be covered by bypassing, because the data does not exist yet. The block then asks for one lost cycle: the program counter and the fetch/decode register keep their contents, and the decode/execute register takes a bubble. One cycle later the load has reached memory/write-back, and its data is bypassed from there. The register file writes in the first half of a cycle and reads in the second half, so a consumer three instructions behind its producer needs no help.

The block is purely combinational. Its outputs settle from the current pipeline-register fields within the same cycle.

Top module: `hazard_ctrl`

## Requirements
- R1: An operand select is 2'b10 (execute/memory result) when the execute/memory write flag is high, its destination is nonzero, and it equals that operand's source number.
- R2: An operand select is 2'b01 (memory/write-back data) when the memory/write-back write flag is high, its destination is nonzero and equal to the source, and the execute/memory stage does not match that same source.
- R3: When both later stages write the same nonzero register that an operand reads, the select is 2'b10, because the younger producer in execute/memory wins.
- R4: An operand select is 2'b00 (register file) when no qualifying match exists. A producer with write flag low, or a destination of register 0, never causes a bypass.
- R5: The two operand selects are worked out independently. Each can take a different one of the three codes in the same cycle, and the code 2'b11 never appears.
- R6: Stall outputs are high when the execute-stage instruction is a load (memory-read flag high) with a nonzero destination that equals either source number of the decode-stage instruction.
- R7: Stall outputs are low when the execute-stage instruction is not a load, when its destination is register 0, or when neither decode source matches it. A consumer two slots behind a load is served by the 2'b01 bypass with no stall.
- R8: The program-counter hold, fetch/decode hold and decode/execute bubble outputs are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | RW | First source register number of the decode-stage instruction |
| id_rs2 | input | RW | Second source register number of the decode-stage instruction |
| ex_rs1 | input | RW | First source register number of the execute-stage instruction |
| ex_rs2 | input | RW | Second source register number of the execute-stage instruction |
| ex_rd | input | RW | Destination register number held in decode/execute |
| ex_memrd | input | 1 | Execute-stage instruction is a load |
| exm_rd | input | RW | Destination register number held in execute/memory |
| exm_we | input | 1 | Execute/memory instruction writes a register |
| mwb_rd | input | RW | Destination register number held in memory/write-back |
| mwb_we | input | 1 | Memory/write-back instruction writes a register |
| fwd_a | output | 2 | Select for ALU operand A: 00 register file, 10 execute/memory, 01 memory/write-back |
| fwd_b | output | 2 | Select for ALU operand B, same encoding |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| idex_bubble | output | 1 | Load a bubble into decode/execute this cycle |

## Verification
The hardest case to reach is the one where both later stages write the same register that an operand reads, and the younger producer must win. Another is a cycle in which the two operands take different codes while a load-use stall is raised for the decode stage. Random register numbers spread over 32 values almost never line up three or four fields at once. So the random phase draws register numbers from a small set that includes register 0, which makes multi-way matches and zero-destination cases common. Directed steps then replay a load followed by its consumer cycle by cycle: stall, bubble, and then the memory/write-back bypass.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  // Operand source codes; the ALU multiplexers decode these bit positions.
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MWB = 2'b01,
    SRC_EXM = 2'b10
  } opsel_e;

  localparam int NUM_OPERANDS = 2;

endpackage

// File: rtl/operand_select.sv
module operand_select #(
  parameter int RW = 5
) (
  input  logic [RW-1:0]     rs,
  input  logic              exm_we,
  input  logic [RW-1:0]     exm_rd,
  input  logic              mwb_we,
  input  logic [RW-1:0]     mwb_rd,
  output hazard_pkg::opsel_e sel,
  output logic              hit_exm,
  output logic              hit_mwb
);
  import hazard_pkg::*;

  // A producer qualifies only when it writes, targets a nonzero register,
  // and that register is the one being read.
  function automatic logic producer_hits(input logic we,
                                         input logic [RW-1:0] rd,
                                         input logic [RW-1:0] src);
    return we && (rd != '0) && (rd == src);
  endfunction

  assign hit_exm = producer_hits(exm_we, exm_rd, rs);
  assign hit_mwb = producer_hits(mwb_we, mwb_rd, rs);

  // Younger producer (execute/memory) takes precedence.
  always_comb begin
    if (hit_exm)      sel = SRC_EXM;
    else if (hit_mwb) sel = SRC_MWB;
    else              sel = SRC_RF;
  end

endmodule

// File: rtl/loaduse_detect.sv
module loaduse_detect #(
  parameter int RW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][RW-1:0] id_src,
  input  logic                    ex_memrd,
  input  logic [RW-1:0]           ex_rd,
  output logic [NSRC-1:0]         src_hit,
  output logic                    stall
);

  function automatic logic load_feeds(input logic is_load,
                                      input logic [RW-1:0] dst,
                                      input logic [RW-1:0] src);
    return is_load && (dst != '0) && (dst == src);
  endfunction

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_hit[g] = load_feeds(ex_memrd, ex_rd, id_src[g]);
  end

  assign stall = |src_hit;

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int NREG = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic [RW-1:0] ex_rs1,
  input  logic [RW-1:0] ex_rs2,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_memrd,
  input  logic [RW-1:0] exm_rd,
  input  logic          exm_we,
  input  logic [RW-1:0] mwb_rd,
  input  logic          mwb_we,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble
);
  import hazard_pkg::*;

  localparam int NOP = NUM_OPERANDS;

  logic [NOP-1:0][RW-1:0] ex_src;
  logic [NOP-1:0][RW-1:0] id_src;
  opsel_e                 op_sel   [NOP];
  logic [NOP-1:0]         op_hit_exm;
  logic [NOP-1:0]         op_hit_mwb;
  logic [NOP-1:0]         lu_hit;
  logic                   lu_stall;

  assign ex_src = {ex_rs2, ex_rs1};
  assign id_src = {id_rs2, id_rs1};

  for (genvar g = 0; g < NOP; g++) begin : g_op
    operand_select #(.RW(RW)) u_sel (
      .rs      (ex_src[g]),
      .exm_we  (exm_we),
      .exm_rd  (exm_rd),
      .mwb_we  (mwb_we),
      .mwb_rd  (mwb_rd),
      .sel     (op_sel[g]),
      .hit_exm (op_hit_exm[g]),
      .hit_mwb (op_hit_mwb[g])
    );
  end

  loaduse_detect #(.RW(RW), .NSRC(NOP)) u_lu (
    .id_src   (id_src),
    .ex_memrd (ex_memrd),
    .ex_rd    (ex_rd),
    .src_hit  (lu_hit),
    .stall    (lu_stall)
  );

  assign fwd_a       = op_sel[0];
  assign fwd_b       = op_sel[1];
  assign pc_hold     = lu_stall;
  assign ifid_hold   = lu_stall;
  assign idex_bubble = lu_stall;

  // Checks relating the ports to one another and to the sub-block events.
  always_comb begin
    // R1: an execute/memory select needs a writing, nonzero, matching producer
    a_r1_exm_needs_match: assert (fwd_a != 2'b10 ||
                                  (exm_we && exm_rd != '0 && exm_rd == ex_rs1))
      else $error("R1 operand A select 10 without qualifying producer");
    // R2: a write-back select needs its own match and no younger match
    a_r2_mwb_needs_match: assert (fwd_b != 2'b01 ||
                                  (mwb_we && mwb_rd != '0 && mwb_rd == ex_rs2 &&
                                   !(exm_we && exm_rd == ex_rs2)))
      else $error("R2 operand B select 01 without qualifying producer");
    // R3: when both stages hit, the younger one wins
    a_r3_younger_wins: assert (!(op_hit_exm[0] && op_hit_mwb[0]) || fwd_a == 2'b10)
      else $error("R3 older producer chosen over younger");
    // R4: register 0 is never bypassed
    a_r4_zero_from_rf: assert ((ex_rs1 != '0 || fwd_a == 2'b00) &&
                               (ex_rs2 != '0 || fwd_b == 2'b00))
      else $error("R4 register 0 bypassed");
    // R5: the unused code never appears
    a_r5_no_code11: assert (fwd_a != 2'b11 && fwd_b != 2'b11)
      else $error("R5 illegal select code");
    // R6: a stall needs a load whose destination is read in decode
    a_r6_stall_cause: assert (!pc_hold ||
                              (ex_memrd && ex_rd != '0 &&
                               (ex_rd == id_rs1 || ex_rd == id_rs2)))
      else $error("R6 stall without load-use dependence");
    // R7: no stall when nothing is loaded
    a_r7_no_load_no_stall: assert (ex_memrd || !idex_bubble)
      else $error("R7 bubble without a load in execute");
    // R8: all three interlock outputs move together
    a_r8_controls_agree: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble &&
                                 idex_bubble == (|lu_hit))
      else $error("R8 interlock outputs disagree");
  end

endmodule

// File: tb/test_hazard_ctrl.sv
`timescale 1ns/1ps
module test_hazard_ctrl;

  localparam int NREG = 32;
  localparam int RW   = $clog2(NREG);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [RW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
  logic [RW-1:0] ex_rd = '0, exm_rd = '0, mwb_rd = '0;
  logic          ex_memrd = 1'b0, exm_we = 1'b0, mwb_we = 1'b0;
  logic [1:0]    fwd_a, fwd_b;
  logic          pc_hold, ifid_hold, idex_bubble;

  hazard_ctrl #(.NREG(NREG)) i_hazard_ctrl (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_memrd(ex_memrd), .exm_rd(exm_rd), .exm_we(exm_we),
    .mwb_rd(mwb_rd), .mwb_we(mwb_we), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
  );

  typedef struct {
    logic [1:0] exp_a;
    logic [1:0] exp_b;
    logic       exp_stall;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference: start from the register file, then let older then younger
  // producers overwrite the choice.
  function automatic logic [1:0] ref_sel(input logic [RW-1:0] src);
    logic [1:0] r;
    r = 2'b00;
    if (src != 0) begin
      if (mwb_we && mwb_rd == src) r = 2'b01;
      if (exm_we && exm_rd == src) r = 2'b10;
    end
    return r;
  endfunction

  function automatic logic ref_stall();
    if (!ex_memrd || ex_rd == 0) return 1'b0;
    return (id_rs1 == ex_rd) || (id_rs2 == ex_rd);
  endfunction

  function automatic string sel_tag(input logic [1:0] s);
    case (s)
      2'b10:   return "R1";
      2'b01:   return "R2";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [RW-1:0] i1, i2, e1, e2, erd,
                       input logic emr,
                       input logic [RW-1:0] xrd, input logic xwe,
                       input logic [RW-1:0] mrd, input logic mwe,
                       input string tag);
    item_t it;
    @(posedge clk);
    #1;
    id_rs1 = i1; id_rs2 = i2; ex_rs1 = e1; ex_rs2 = e2; ex_rd = erd;
    ex_memrd = emr; exm_rd = xrd; exm_we = xwe; mwb_rd = mrd; mwb_we = mwe;
    it.exp_a     = ref_sel(e1);
    it.exp_b     = ref_sel(e2);
    it.exp_stall = ref_stall();
    it.tag       = tag;
    q.push_back(it);
  endtask

  // Monitor: compare at the falling edge, well after the inputs settled.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        item_t it;
        string ta, tb, ts;
        it = q.pop_front();
        ta = (it.tag != "") ? it.tag : sel_tag(it.exp_a);
        tb = (it.tag != "") ? it.tag : sel_tag(it.exp_b);
        ts = (it.tag != "") ? it.tag : (it.exp_stall ? "R6" : "R7");
        check(fwd_a == it.exp_a, ta, "fwd_a", fwd_a, it.exp_a);
        check(fwd_b == it.exp_b, tb, "fwd_b", fwd_b, it.exp_b);
        check(pc_hold == it.exp_stall, ts, "pc_hold", pc_hold, it.exp_stall);
        check(pc_hold == ifid_hold && ifid_hold == idex_bubble, "R8",
              "hold/bubble agree", {pc_hold, ifid_hold, idex_bubble},
              {3{it.exp_stall}});
      end
    end
  end

  // Watchdog
  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Idle state: all inputs zero, everything from the register file, no stall
    apply(0,0,0,0,0,0, 0,0, 0,0, "R4");
    // R1: operand A fed by execute/memory
    apply(0,0,5,6,0,0, 5,1, 0,0, "R1");
    // R2: operand B fed by memory/write-back
    apply(0,0,4,7,0,0, 9,1, 7,1, "R2");
    // R3: both stages write register 3, read by both operands
    apply(0,0,3,3,0,0, 3,1, 3,1, "R3");
    // R4: write flag low on both producers
    apply(0,0,8,8,0,0, 8,0, 8,0, "R4");
    // R4: destination 0 on both producers, sources 0
    apply(0,0,0,0,0,0, 0,1, 0,1, "R4");
    // R5: A from execute/memory, B from write-back in same cycle
    apply(0,0,10,11,0,0, 10,1, 11,1, "R5");
    // R5: A from register file, B from execute/memory
    apply(0,0,12,13,0,0, 13,1, 12,0, "R5");
    // R6: load into r2 in execute, decode reads r2 as first source
    apply(2,9,0,0,2,1, 0,0, 0,0, "R6");
    // R6: match on second decode source, with operand bypass at the same time
    apply(9,2,5,1,2,1, 5,1, 1,1, "R6");
    // R7: not a load, destination matches decode
    apply(2,2,0,0,2,0, 0,0, 0,0, "R7");
    // R7: load into register 0
    apply(0,0,0,0,0,1, 0,0, 0,0, "R7");
    // R7: load with no decode match
    apply(3,4,0,0,5,1, 0,0, 0,0, "R7");
    // Walk of load r6 followed by consumer of r6:
    apply(6,1,0,0,6,1, 0,0, 0,0, "R6");   // stall raised
    apply(6,1,0,0,0,0, 6,1, 0,0, "R7");   // bubble in execute, load in exe/mem
    apply(0,0,6,1,0,0, 0,0, 6,1, "R2");   // consumer served from write-back
    // Consumer two behind the load: bypass from write-back, no stall
    apply(0,0,1,6,0,0, 7,1, 6,1, "R7");
    // Consumer three behind: load already written, register file used
    apply(0,0,6,0,0,0, 0,0, 0,0, "R4");

    // Random phase with small register range to force coincidences
    for (int n = 0; n < 3000; n++) begin
      apply($urandom_range(0,3), $urandom_range(0,3), $urandom_range(0,3),
            $urandom_range(0,3), $urandom_range(0,3), 1'($urandom_range(0,1)),
            $urandom_range(0,3), 1'($urandom_range(0,1)),
            $urandom_range(0,3), 1'($urandom_range(0,1)), "");
    end

    while (q.size() != 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule